// File: doc/BRIEF.md
# Dual-Channel Register-Mapped GPIO Controller

This block is a general-purpose I/O peripheral with two independent pin channels, each configurable from 1 to 32 pins wide. A simple 32-bit register bus (valid, write, byte address, write data, read data) sets the output value and direction of every pin. It also reads back the synchronized level of every input pin.

Each channel watches its synchronized input word. When that word changes, the channel latches a pending bit. The pending bits of both channels are masked by a per-channel enable and then by one global gate. Together they drive a single registered interrupt line. Software clears a pending bit by writing a one to it.

Top module: `gpio_dual_ctrl`

## Requirements
- R1: After reset every output enable is 0 and every output value is 0. The pending bits are 0 and the interrupt line is 0. Both direction registers read back as all ones over the channel width.
- R2: Byte addresses are fixed as follows. Channel one has its output data register at 0x000 and its direction register at 0x004. Channel two uses the same layout shifted by 8, so its data register is at 0x008 and its direction register at 0x00C. A read of a data address returns the sampled input levels. A read of a direction address returns the direction register.
- R3: A direction bit of 1 makes its pin an input (output enable 0). A direction bit of 0 makes it an output (output enable 1). A write to a data address shows up on the output value pins after the clock edge that takes the write.
- R4: Input pins pass through two flops. A read of the data address reflects a new input level two clock edges after the pin changes. Bits at or above a channel's width read as 0, and writes to those bits have no effect.
- R5: A channel's pending bit sets on the clock edge after its synchronized input word differs from the previous sample. The pending register is at 0x120, with bit 0 for channel one and bit 1 for channel two.
- R6: Writing a 1 to a pending bit clears it. Writing a 0 leaves it unchanged.
- R7: When a clearing write and a new input change reach the same pending bit in the same cycle, the bit stays set.
- R8: The interrupt line is a registered version of three terms combined. The first is bit 31 of the global gate register at 0x11C. It is ANDed with the OR over channels of (pending AND enable). The enable register is at 0x128, with bit 0 for channel one and bit 1 for channel two. With the gate at 0 the line stays low.
- R9: Writes to addresses outside the map change no register, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, 0 when not reading) |
| ch1_in | input | W1 | Channel one input pins |
| ch1_out | output | W1 | Channel one output values |
| ch1_oe | output | W1 | Channel one output enables |
| ch2_in | input | W2 | Channel two input pins |
| ch2_out | output | W2 | Channel two output values |
| ch2_oe | output | W2 | Channel two output enables |
| irq | output | 1 | Shared interrupt |

## Verification
The bench puts a clearing write on the same edge at which a pending bit sets. A design that gave the clear priority would lose that event and read back 0. It writes zeros, and a one to the other channel's bit only, into the pending register. A design that overwrote the register instead of clearing by ones would drop a live event. It raises events with the global gate off, and with only the other channel enabled, to catch an interrupt that ignores a mask. It also uses a channel narrower than 32 bits and unmapped addresses, to expose writes that leak into unused bits or into the wrong register.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
   localparam int unsigned ADDR_W     = 9;
   localparam int unsigned DATA_W     = 32;
   localparam int unsigned N_CH       = 2;
   localparam int unsigned MAX_PINS   = 32;
   localparam int unsigned GATE_BIT   = 31;
   localparam logic [ADDR_W-1:0] OFS_DAT    = 9'h000;
   localparam logic [ADDR_W-1:0] OFS_DIR    = 9'h004;
   localparam logic [ADDR_W-1:0] CH_STRIDE  = 9'h008;
   localparam logic [ADDR_W-1:0] OFS_GATE   = 9'h11C;
   localparam logic [ADDR_W-1:0] OFS_PEND   = 9'h120;
   localparam logic [ADDR_W-1:0] OFS_MASK   = 9'h128;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_DAT1,
      SEL_DIR1,
      SEL_DAT2,
      SEL_DIR2,
      SEL_GATE,
      SEL_PEND,
      SEL_MASK
   } reg_sel_t;
endpackage

// File: rtl/gpio_dual_decode.sv
module gpio_dual_decode
   import gpio_dual_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);
   always_comb begin
      case (addr)
         OFS_DAT:             sel = SEL_DAT1;
         OFS_DIR:             sel = SEL_DIR1;
         OFS_DAT + CH_STRIDE: sel = SEL_DAT2;
         OFS_DIR + CH_STRIDE: sel = SEL_DIR2;
         OFS_GATE:            sel = SEL_GATE;
         OFS_PEND:            sel = SEL_PEND;
         OFS_MASK:            sel = SEL_MASK;
         default:             sel = SEL_NONE;
      endcase
   end
endmodule

// File: rtl/gpio_dual_port.sv
module gpio_dual_port #(
   parameter int unsigned W    = 32,
   parameter int unsigned SYNC = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pad_in,
   input  logic         dat_we,
   input  logic         dir_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] level,
   output logic [W-1:0] dir_q,
   output logic         edge_seen
);
   if (W < 1 || W > gpio_dual_pkg::MAX_PINS) begin : g_bad_width
      $error("gpio_dual_port: W must be 1..32");
   end
   if (SYNC < 2) begin : g_bad_sync
      $error("gpio_dual_port: SYNC must be at least 2");
   end

   logic [W-1:0] dat_q;
   logic [W-1:0] prev_q;
   logic [SYNC-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg[0] <= '0;
      end else begin
         stg[0] <= pad_in;
      end
   end

   for (genvar i = 1; i < SYNC; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg[i] <= '0;
         end else begin
            stg[i] <= stg[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_q  <= '0;
         dir_q  <= '1;
         prev_q <= '0;
      end else begin
         prev_q <= stg[SYNC-1];
         if (dat_we) dat_q <= wdata;
         if (dir_we) dir_q <= wdata;
      end
   end

   assign level     = stg[SYNC-1];
   assign edge_seen = (stg[SYNC-1] != prev_q);
   assign pad_out   = dat_q;
   assign pad_oe    = ~dir_q;
endmodule

// File: rtl/gpio_dual_irq.sv
module gpio_dual_irq #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic         pend_we,
   input  logic         mask_we,
   input  logic         gate_we,
   input  logic [N-1:0] wbits,
   input  logic         gate_bit,
   output logic [N-1:0] pend_q,
   output logic [N-1:0] mask_q,
   output logic         gate_q,
   output logic         irq
);
   if (N < 1 || N > 32) begin : g_bad_n
      $error("gpio_dual_irq: N must be 1..32");
   end

   logic [N-1:0] clr;
   assign clr = pend_we ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '0;
         gate_q <= 1'b0;
         irq    <= 1'b0;
      end else begin
         pend_q <= (pend_q & ~clr) | ev;
         if (mask_we) mask_q <= wbits;
         if (gate_we) gate_q <= gate_bit;
         irq <= gate_q & |(pend_q & mask_q);
      end
   end
endmodule

// File: rtl/gpio_dual_ctrl.sv
module gpio_dual_ctrl
   import gpio_dual_pkg::*;
#(
   parameter int unsigned W1 = 32,
   parameter int unsigned W2 = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [W1-1:0]     ch1_in,
   output logic [W1-1:0]     ch1_out,
   output logic [W1-1:0]     ch1_oe,
   input  logic [W2-1:0]     ch2_in,
   output logic [W2-1:0]     ch2_out,
   output logic [W2-1:0]     ch2_oe,
   output logic              irq
);
   reg_sel_t     sel;
   logic         wr;
   logic [N_CH-1:0] ev;
   logic [N_CH-1:0] pend_q;
   logic [N_CH-1:0] mask_q;
   logic         gate_q;
   logic [W1-1:0] lvl1, dir1;
   logic [W2-1:0] lvl2, dir2;

   assign wr = bus_valid & bus_write;

   gpio_dual_decode u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   gpio_dual_port #(.W(W1), .SYNC(2)) u_ch1 (
      .clk       (clk),
      .rst_n     (rst_n),
      .pad_in    (ch1_in),
      .dat_we    (wr && sel == SEL_DAT1),
      .dir_we    (wr && sel == SEL_DIR1),
      .wdata     (bus_wdata[W1-1:0]),
      .pad_out   (ch1_out),
      .pad_oe    (ch1_oe),
      .level     (lvl1),
      .dir_q     (dir1),
      .edge_seen (ev[0])
   );

   gpio_dual_port #(.W(W2), .SYNC(2)) u_ch2 (
      .clk       (clk),
      .rst_n     (rst_n),
      .pad_in    (ch2_in),
      .dat_we    (wr && sel == SEL_DAT2),
      .dir_we    (wr && sel == SEL_DIR2),
      .wdata     (bus_wdata[W2-1:0]),
      .pad_out   (ch2_out),
      .pad_oe    (ch2_oe),
      .level     (lvl2),
      .dir_q     (dir2),
      .edge_seen (ev[1])
   );

   gpio_dual_irq #(.N(N_CH)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev),
      .pend_we  (wr && sel == SEL_PEND),
      .mask_we  (wr && sel == SEL_MASK),
      .gate_we  (wr && sel == SEL_GATE),
      .wbits    (bus_wdata[N_CH-1:0]),
      .gate_bit (bus_wdata[GATE_BIT]),
      .pend_q   (pend_q),
      .mask_q   (mask_q),
      .gate_q   (gate_q),
      .irq      (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_valid && !bus_write) begin
         case (sel)
            SEL_DAT1: bus_rdata[W1-1:0]   = lvl1;
            SEL_DIR1: bus_rdata[W1-1:0]   = dir1;
            SEL_DAT2: bus_rdata[W2-1:0]   = lvl2;
            SEL_DIR2: bus_rdata[W2-1:0]   = dir2;
            SEL_GATE: bus_rdata[GATE_BIT] = gate_q;
            SEL_PEND: bus_rdata[N_CH-1:0] = pend_q;
            SEL_MASK: bus_rdata[N_CH-1:0] = mask_q;
            default:  bus_rdata           = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_dual_ctrl_chk.sv
module gpio_dual_ctrl_chk
   import gpio_dual_pkg::*;
#(
   parameter int unsigned W1 = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [W1-1:0]     ch1_oe,
   input logic [N_CH-1:0]   ev,
   input logic [N_CH-1:0]   pend_q,
   input logic [N_CH-1:0]   mask_q,
   input logic              gate_q,
   input logic              irq
);
   logic dir1_wr, pend_wr;
   assign dir1_wr = bus_valid && bus_write && bus_addr == OFS_DIR;
   assign pend_wr = bus_valid && bus_write && bus_addr == OFS_PEND;

   assert_dir_to_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dir1_wr |=> (ch1_oe == ~$past(bus_wdata[W1-1:0])));

   assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev[0] |=> pend_q[0]);

   assert_one_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_wr && bus_wdata[0] && !ev[0]) |=> !pend_q[0]);

   assert_zero_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_wr && !bus_wdata[1] && pend_q[1]) |=> pend_q[1]);

   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_wr && bus_wdata[1] && ev[1]) |=> pend_q[1]);

   assert_gate_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_q |=> !irq);

   assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(gate_q && |(pend_q & mask_q)));
endmodule

bind gpio_dual_ctrl gpio_dual_ctrl_chk #(.W1(W1)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .ch1_oe    (ch1_oe),
   .ev        (ev),
   .pend_q    (pend_q),
   .mask_q    (mask_q),
   .gate_q    (gate_q),
   .irq       (irq)
);

// File: tb/gpio_dual_ctrl_test.sv
module gpio_dual_ctrl_test;
   localparam int unsigned TW1 = 32;
   localparam int unsigned TW2 = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [8:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [TW1-1:0] ch1_in = '0, ch1_out, ch1_oe;
   logic [TW2-1:0] ch2_in = '0, ch2_out, ch2_oe;
   logic        irq;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_dat1, m_dir1, m_dat2, m_dir2, m_in1, m_in2;
   logic [1:0]  m_pend;

   always #2 clk = ~clk;

   gpio_dual_ctrl #(.W1(TW1), .W2(TW2)) uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ch1_in(ch1_in), .ch1_out(ch1_out), .ch1_oe(ch1_oe),
      .ch2_in(ch2_in), .ch2_out(ch2_out), .ch2_oe(ch2_oe), .irq(irq));

   function automatic logic [31:0] wmask(input int unsigned w);
      return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_valid = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic check_pins();
      chk("R3 ch1_out", 32'(ch1_out), m_dat1);
      chk("R3 ch1_oe", 32'(ch1_oe), ~m_dir1 & wmask(TW1));
      chk("R3 ch2_out", 32'(ch2_out), m_dat2);
      chk("R3 ch2_oe", 32'(ch2_oe), ~m_dir2 & wmask(TW2));
   endtask

   task automatic drive_in(input int ch, input logic [31:0] v);
      @(negedge clk);
      if (ch == 0) begin
         if ((v & wmask(TW1)) != m_in1) m_pend[0] = 1'b1;
         m_in1 = v & wmask(TW1);
         ch1_in = v[TW1-1:0];
      end else begin
         if ((v & wmask(TW2)) != m_in2) m_pend[1] = 1'b1;
         m_in2 = v & wmask(TW2);
         ch2_in = v[TW2-1:0];
      end
   endtask

   initial begin : watchdog
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      logic [31:0] v;
      int unsigned op;
      v = $urandom(32'd1234);
      m_dat1 = '0; m_dat2 = '0; m_in1 = '0; m_in2 = '0; m_pend = '0;
      m_dir1 = wmask(TW1); m_dir2 = wmask(TW2);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check_pins();
      chk("R1 irq", 32'(irq), 32'h0);
      rd(9'h004, d); chk("R1 dir1", d, wmask(TW1));
      rd(9'h00C, d); chk("R1 dir2", d, wmask(TW2));
      rd(9'h120, d); chk("R1 pend", d, 32'h0);

      // R2 R3 directed writes, R4 narrow channel masking
      wr(9'h000, 32'hA5A5_0F0F); m_dat1 = 32'hA5A5_0F0F;
      wr(9'h004, 32'h0000_FFFF); m_dir1 = 32'h0000_FFFF;
      wr(9'h008, 32'hFFFF_FFFF); m_dat2 = wmask(TW2);
      wr(9'h00C, 32'hFFFF_00F0); m_dir2 = 32'h0000_00F0;
      check_pins();
      rd(9'h00C, d); chk("R4 dir2 upper bits", d, 32'h0000_00F0);
      rd(9'h004, d); chk("R2 dir1 readback", d, 32'h0000_FFFF);

      // R9 unmapped address
      wr(9'h010, 32'hFFFF_FFFF);
      wr(9'h124, 32'hFFFF_FFFF);
      check_pins();
      rd(9'h010, d); chk("R9 unmapped read", d, 32'h0);
      rd(9'h128, d); chk("R9 mask untouched", d, 32'h0);

      // R4 R5 input sampling and pending
      drive_in(0, 32'h1234_5678);
      settle();
      rd(9'h000, d); chk("R4 ch1 level", d, m_in1);
      rd(9'h120, d); chk("R5 pend ch1", d, 32'(m_pend));
      drive_in(1, 32'hFFFF_8001);
      settle();
      rd(9'h008, d); chk("R4 ch2 level upper zero", d, 32'h0000_8001);
      rd(9'h120, d); chk("R5 pend both", d, 32'(m_pend));

      // R6 zero write keeps, one clears only its bit
      wr(9'h120, 32'h0); rd(9'h120, d); chk("R6 zero keeps", d, 32'h3);
      wr(9'h120, 32'h2); m_pend = 2'b01;
      rd(9'h120, d); chk("R6 clear ch2 only", d, 32'h1);
      wr(9'h120, 32'h1); m_pend = 2'b00;
      rd(9'h120, d); chk("R6 clear ch1", d, 32'h0);

      // R7 set wins over clear in same cycle
      @(negedge clk); ch1_in = ~ch1_in; m_in1 = 32'(ch1_in);
      @(negedge clk);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 9'h120; bus_wdata = 32'h1;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      rd(9'h120, d); chk("R7 set wins", d, 32'h1);
      wr(9'h120, 32'h3);

      // R8 interrupt combining
      wr(9'h128, 32'h1);
      drive_in(0, 32'h0); m_pend = 2'b00;
      settle();
      chk("R8 gate off", 32'(irq), 32'h0);
      wr(9'h11C, 32'h8000_0000);
      rd(9'h11C, d); chk("R8 gate readback", d, 32'h8000_0000);
      chk("R8 gate on", 32'(irq), 32'h1);
      wr(9'h120, 32'h1);
      @(negedge clk);
      chk("R8 cleared", 32'(irq), 32'h0);
      drive_in(1, 32'h0000_0002); m_pend = 2'b00;
      settle();
      chk("R8 ch2 masked", 32'(irq), 32'h0);
      wr(9'h128, 32'h3);
      @(negedge clk);
      chk("R8 ch2 enabled", 32'(irq), 32'h1);
      wr(9'h11C, 32'h7FFF_FFFF);
      @(negedge clk);
      chk("R8 gate bit cleared", 32'(irq), 32'h0);
      wr(9'h120, 32'h3);
      wr(9'h128, 32'h0);

      // Random mix
      for (int i = 0; i < 300; i++) begin
         op = $urandom % 6;
         v  = $urandom;
         case (op)
            0: begin wr(9'h000, v); m_dat1 = v & wmask(TW1); check_pins(); end
            1: begin wr(9'h004, v); m_dir1 = v & wmask(TW1); check_pins(); end
            2: begin wr(9'h008, v); m_dat2 = v & wmask(TW2); check_pins(); end
            3: begin wr(9'h00C, v); m_dir2 = v & wmask(TW2); check_pins(); end
            default: begin
               if ($urandom % 4 == 0) v = (op == 4) ? m_in1 : m_in2;
               drive_in(op - 4, v);
               settle();
               rd(9'h000, d); chk("R4 rand ch1", d, m_in1);
               rd(9'h008, d); chk("R4 rand ch2", d, m_in2);
               rd(9'h120, d); chk("R5 rand pend", d, 32'(m_pend));
               chk("R8 rand irq off", 32'(irq), 32'h0);
               wr(9'h120, 32'h3); m_pend = 2'b00;
               rd(9'h120, d); chk("R6 rand clear", d, 32'h0);
            end
         endcase
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule